// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Fabric

This block is an eight-port multistage interconnect. It is built from three ranks of 2x2 switching elements, with four elements in each rank. Before each rank, the lines pass through a perfect-shuffle permutation. No central controller is involved. Each element sets itself from one bit of the destination tag carried by the cell it is handling, and the most significant bit is used in the first rank. Once per cell time, every input may present a valid flag, a destination tag and a payload. All routing is decided combinationally within one clock, and one register rank drives the outputs.

The fabric has no buffers. When two cells ask for the same output of an element, one cell is kept and the other is discarded. This happens both when two cells collide on an internal link and when they are headed for the same final port. Each source learns the fate of its cell through a per-input acknowledge. The acknowledge appears in the same clock as the delivered cell, so the surrounding logic can hold a lost cell and offer it again later.

Top module: `sen_fabric`

## Requirements
- R1: While `rst_ni` is low, and at the first clock edge after its release, every output valid, tag, payload and acknowledge bit is 0.
- R2: A valid cell on input i with tag d that is not dropped appears on output d on the clock edge after it is presented, with tag and payload unchanged. Input i uses `in_dest_i[3i+2:3i]` and `in_data_i[16i+15:16i]`, and outputs use the same layout.
- R3: Before each rank, line p moves to the left rotation of its 3-bit index. Rank k (k = 0, 1, 2) sends a cell to the element's upper output (even line) when tag bit 2-k is 0 and to the lower output (odd line) when it is 1. As a result, exactly 4096 of the 40320 full permutations deliver all eight cells.
- R4: An internal link clash drops a cell. Input 0 to output 3 together with input 4 to output 2 delivers the input 0 cell and drops the input 4 cell.
- R5: An output clash drops a cell. Inputs 1 and 3 both bound for output 6 deliver the input 1 cell and drop the input 3 cell.
- R6: When two valid cells in one element want the same element output, the cell on the element's even (lower-numbered) input is kept and the other is dropped, whatever their final tags are.
- R7: An input with valid low is never delivered or acknowledged, and it never takes a link from another cell.
- R8: An output that carries no cell drives valid 0, tag 0 and payload 0.
- R9: `ack_o[i]` is 1 exactly in the cycle where the cell from input i appears on an output, and 0 when that cell was dropped.
- R10: In every cycle, the number of set acknowledge bits equals the number of valid outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 8 | Per-input cell present |
| in_dest_i | input | 24 | Per-input 3-bit destination tag |
| in_data_i | input | 128 | Per-input 16-bit payload |
| out_valid_o | output | 8 | Per-output cell present |
| out_dest_o | output | 24 | Per-output tag of delivered cell |
| out_data_o | output | 128 | Per-output payload |
| ack_o | output | 8 | Per-input delivery acknowledge |

## Verification
The bench runs all 40320 full permutations and checks that exactly 4096 of them pass intact. A design with a wrong shuffle direction or a wrong tag bit order would either misroute cells or change that count. Directed cases target the internal clash (0 to 3 with 4 to 2) and the shared-output clash (1 and 3 to 6). A design that gave priority to the odd element input, or that let both cells through, would acknowledge the wrong source or corrupt a payload. Another case places an idle input whose stale tag matches a live cell's path; a design that lets invalid cells claim links would drop the live cell. Random partial loads with repeated tags exercise clashes in all three ranks.

// File: rtl/sen_pkg.sv
package sen_pkg;
  typedef enum logic {SW_THROUGH = 1'b0, SW_CROSS = 1'b1} sw_state_e;

  // left rotation of an lg-bit line index
  function automatic int shuffle_idx(int idx, int lg);
    return ((idx << 1) | (idx >> (lg - 1))) & ((1 << lg) - 1);
  endfunction
endpackage

// File: rtl/sen_element.sv
module sen_element #(
  parameter int LG     = 3,
  parameter int DATA_W = 16,
  parameter int BIT    = 0
) (
  input  logic [1:0]             v_i,
  input  logic [1:0][LG-1:0]     dest_i,
  input  logic [1:0][LG-1:0]     src_i,
  input  logic [1:0][DATA_W-1:0] data_i,
  output logic [1:0]             v_o,
  output logic [1:0][LG-1:0]     dest_o,
  output logic [1:0][LG-1:0]     src_o,
  output logic [1:0][DATA_W-1:0] data_o
);
  import sen_pkg::*;

  sw_state_e  state;
  logic       want0, want1, clash;
  logic [1:0] keep;

  always_comb begin
    want0 = dest_i[0][BIT];
    want1 = dest_i[1][BIT];
    clash = v_i[0] && v_i[1] && (want0 == want1);
    keep  = {v_i[1] & ~clash, v_i[0]};
    if (v_i[0])      state = want0 ? SW_CROSS : SW_THROUGH;
    else if (v_i[1]) state = want1 ? SW_THROUGH : SW_CROSS;
    else             state = SW_THROUGH;
  end

  always_comb begin
    if (state == SW_THROUGH) begin
      v_o    = keep;
      dest_o = dest_i;
      src_o  = src_i;
      data_o = data_i;
    end else begin
      v_o    = {keep[0], keep[1]};
      dest_o = {dest_i[0], dest_i[1]};
      src_o  = {src_i[0], src_i[1]};
      data_o = {data_i[0], data_i[1]};
    end
  end

  always_comb begin
    if (clash) begin
      assert_elem_even_wins_R6: assert (v_o[want0] && src_o[want0] == src_i[0] && !v_o[~want0]);
    end
  end
endmodule

// File: rtl/sen_stage.sv
module sen_stage #(
  parameter int N      = 8,
  parameter int LG     = 3,
  parameter int DATA_W = 16,
  parameter int BIT    = 0
) (
  input  logic [N-1:0]             v_i,
  input  logic [N-1:0][LG-1:0]     dest_i,
  input  logic [N-1:0][LG-1:0]     src_i,
  input  logic [N-1:0][DATA_W-1:0] data_i,
  output logic [N-1:0]             v_o,
  output logic [N-1:0][LG-1:0]     dest_o,
  output logic [N-1:0][LG-1:0]     src_o,
  output logic [N-1:0][DATA_W-1:0] data_o
);
  localparam int N_EL = N / 2;

  logic [N-1:0]             sh_v;
  logic [N-1:0][LG-1:0]     sh_d, sh_s;
  logic [N-1:0][DATA_W-1:0] sh_x;

  for (genvar i = 0; i < N; i++) begin : g_shuf
    localparam int P = sen_pkg::shuffle_idx(i, LG);
    assign sh_v[P] = v_i[i];
    assign sh_d[P] = dest_i[i];
    assign sh_s[P] = src_i[i];
    assign sh_x[P] = data_i[i];
  end

  for (genvar e = 0; e < N_EL; e++) begin : g_el
    sen_element #(.LG(LG), .DATA_W(DATA_W), .BIT(BIT)) u_el (
      .v_i    (sh_v[2*e+1:2*e]),
      .dest_i (sh_d[2*e+1:2*e]),
      .src_i  (sh_s[2*e+1:2*e]),
      .data_i (sh_x[2*e+1:2*e]),
      .v_o    (v_o[2*e+1:2*e]),
      .dest_o (dest_o[2*e+1:2*e]),
      .src_o  (src_o[2*e+1:2*e]),
      .data_o (data_o[2*e+1:2*e])
    );
  end

  always_comb begin
    assert_stage_no_gain_R7: assert ($countones(v_o) <= $countones(v_i));
  end
endmodule

// File: rtl/sen_fabric.sv
module sen_fabric #(
  parameter  int N_PORTS = 8,
  parameter  int DATA_W  = 16,
  localparam int LG      = $clog2(N_PORTS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_PORTS-1:0]          in_valid_i,
  input  logic [N_PORTS*LG-1:0]       in_dest_i,
  input  logic [N_PORTS*DATA_W-1:0]   in_data_i,
  output logic [N_PORTS-1:0]          out_valid_o,
  output logic [N_PORTS*LG-1:0]       out_dest_o,
  output logic [N_PORTS*DATA_W-1:0]   out_data_o,
  output logic [N_PORTS-1:0]          ack_o
);
  localparam int N      = N_PORTS;
  localparam int STAGES = LG;

  logic [STAGES:0][N-1:0]             lv;
  logic [STAGES:0][N-1:0][LG-1:0]     ld, ls;
  logic [STAGES:0][N-1:0][DATA_W-1:0] lx;

  assign lv[0] = in_valid_i;
  for (genvar i = 0; i < N; i++) begin : g_in
    assign ld[0][i] = in_dest_i[i*LG +: LG];
    assign ls[0][i] = LG'(i);
    assign lx[0][i] = in_data_i[i*DATA_W +: DATA_W];
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    sen_stage #(.N(N), .LG(LG), .DATA_W(DATA_W), .BIT(LG-1-k)) u_stage (
      .v_i    (lv[k]),   .dest_i (ld[k]),   .src_i (ls[k]),   .data_i (lx[k]),
      .v_o    (lv[k+1]), .dest_o (ld[k+1]), .src_o (ls[k+1]), .data_o (lx[k+1])
    );
  end

  logic [N-1:0] ack_d;
  always_comb begin
    ack_d = '0;
    for (int j = 0; j < N; j++)
      if (lv[STAGES][j]) ack_d[ls[STAGES][j]] = 1'b1;
  end

  logic [N-1:0]             valid_q, ack_q;
  logic [N-1:0][LG-1:0]     dest_q, src_q;
  logic [N-1:0][DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      ack_q   <= '0;
      dest_q  <= '0;
      src_q   <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= lv[STAGES];
      ack_q   <= ack_d;
      for (int j = 0; j < N; j++) begin
        dest_q[j] <= lv[STAGES][j] ? ld[STAGES][j] : '0;
        src_q[j]  <= lv[STAGES][j] ? ls[STAGES][j] : '0;
        data_q[j] <= lv[STAGES][j] ? lx[STAGES][j] : '0;
      end
    end
  end

  assign out_valid_o = valid_q;
  assign ack_o       = ack_q;
  for (genvar j = 0; j < N; j++) begin : g_out
    assign out_dest_o[j*LG +: LG]         = dest_q[j];
    assign out_data_o[j*DATA_W +: DATA_W] = data_q[j];

    assert_dest_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[j] |-> out_dest_o[j*LG +: LG] == LG'(j));
    assert_payload_kept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[j] |-> out_data_o[j*DATA_W +: DATA_W] == DATA_W'($past(in_data_i) >> (DATA_W * src_q[j])));
    assert_ack_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[j] |-> ack_o[src_q[j]]);
    assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !out_valid_o[j] |-> (out_dest_o[j*LG +: LG] == '0 && out_data_o[j*DATA_W +: DATA_W] == '0));
  end

  assert_reset_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (out_valid_o == '0 && ack_o == '0));
  assert_ack_count_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(ack_o) == $countones(out_valid_o));
  assert_ack_needs_valid_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ack_o & ~$past(in_valid_i)) == '0));
endmodule

// File: tb/sen_fabric_bench.sv
module sen_fabric_bench;
  localparam int N  = 8;
  localparam int LG = 3;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]    in_v = '0;
  logic [N*LG-1:0] in_d = '0;
  logic [N*DW-1:0] in_x = '0;
  logic [N-1:0]    out_v;
  logic [N*LG-1:0] out_d;
  logic [N*DW-1:0] out_x;
  logic [N-1:0]    ack;

  sen_fabric u_sen_fabric (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_v), .in_dest_i(in_d), .in_data_i(in_x),
    .out_valid_o(out_v), .out_dest_o(out_d), .out_data_o(out_x), .ack_o(ack)
  );

  int checks = 0, fails = 0;
  bit cv[N];
  int cd[N], cx[N];
  bit ev[N], ea[N];
  int ed[N], ex[N];

  function automatic int rot(int l);
    return ((l << 1) & (N - 1)) | (l >> (LG - 1));
  endfunction

  // behavioural reference: walk cells rank by rank, even line claims first
  function automatic void model();
    int occ[N];
    int nxt[N];
    for (int l = 0; l < N; l++) occ[l] = cv[l] ? l : -1;
    for (int k = 0; k < LG; k++) begin
      for (int l = 0; l < N; l++) nxt[l] = -1;
      for (int l = 0; l < N; l++) if (occ[l] >= 0) nxt[rot(l)] = occ[l];
      for (int l = 0; l < N; l++) occ[l] = -1;
      for (int l = 0; l < N; l++) begin
        if (nxt[l] >= 0) begin
          int t;
          t = (l & ~1) | ((cd[nxt[l]] >> (LG - 1 - k)) & 1);
          if (occ[t] < 0) occ[t] = nxt[l];
        end
      end
    end
    for (int j = 0; j < N; j++) ea[j] = 1'b0;
    for (int j = 0; j < N; j++) begin
      ev[j] = occ[j] >= 0;
      ed[j] = ev[j] ? cd[occ[j]] : 0;
      ex[j] = ev[j] ? cx[occ[j]] : 0;
      if (ev[j]) ea[occ[j]] = 1'b1;
    end
  endfunction

  task automatic check_val(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic apply_and_compare();
    int na, nv;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      in_v[i]         = cv[i];
      in_d[i*LG +: LG] = cd[i][LG-1:0];
      in_x[i*DW +: DW] = cx[i][DW-1:0];
    end
    model();
    @(posedge clk);
    #1;
    for (int j = 0; j < N; j++) begin
      checks++;
      if (out_v[j] != ev[j] || int'(out_d[j*LG +: LG]) != ed[j] || int'(out_x[j*DW +: DW]) != ex[j]) begin
        fails++;
        $display("FAIL R2/R8 out%0d actual v=%0b d=%0d x=%0h expected v=%0b d=%0d x=%0h",
                 j, out_v[j], out_d[j*LG +: LG], out_x[j*DW +: DW], ev[j], ed[j], ex[j]);
      end
    end
    na = 0; nv = 0;
    for (int j = 0; j < N; j++) begin
      check_val("R9", int'(ack[j]), int'(ea[j]), $sformatf("ack[%0d]", j));
      na += int'(ack[j]);
      nv += int'(out_v[j]);
    end
    check_val("R10", na, nv, "ack count vs valid count");
  endtask

  task automatic clear_cells();
    for (int i = 0; i < N; i++) begin
      cv[i] = 1'b0; cd[i] = 0; cx[i] = 0;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int full_ok;
    clear_cells();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check_val("R1", int'(out_v), 0, "out_valid in reset");
    check_val("R1", int'(ack), 0, "ack in reset");
    check_val("R1", int'(|out_x) + int'(|out_d), 0, "out tag/payload in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check_val("R1", int'(out_v), 0, "out_valid after release");

    // R3: identity permutation passes intact
    for (int i = 0; i < N; i++) begin cv[i] = 1'b1; cd[i] = i; cx[i] = 16'h1000 + i; end
    apply_and_compare();
    check_val("R3", int'(ack), 8'hff, "identity acks");

    // R4: internal link clash
    clear_cells();
    cv[0] = 1'b1; cd[0] = 3; cx[0] = 16'haaa0;
    cv[4] = 1'b1; cd[4] = 2; cx[4] = 16'hbbb4;
    apply_and_compare();
    check_val("R4", int'(ack[0]), 1, "ack0");
    check_val("R4", int'(ack[4]), 0, "ack4");
    check_val("R4", int'(out_v[3]), 1, "out3 valid");
    check_val("R4", int'(out_v[2]), 0, "out2 valid");

    // R6: same pair, tags swapped, even element input still wins
    cd[0] = 2; cd[4] = 3;
    apply_and_compare();
    check_val("R6", int'(ack[0]), 1, "ack0 swapped tags");
    check_val("R6", int'(ack[4]), 0, "ack4 swapped tags");
    check_val("R6", int'(out_x[2*DW +: DW]), 16'haaa0, "out2 payload");

    // R5: output clash on port 6
    clear_cells();
    cv[1] = 1'b1; cd[1] = 6; cx[1] = 16'h1111;
    cv[3] = 1'b1; cd[3] = 6; cx[3] = 16'h3333;
    apply_and_compare();
    check_val("R5", int'(ack[1]), 1, "ack1");
    check_val("R5", int'(ack[3]), 0, "ack3");
    check_val("R5", int'(out_x[6*DW +: DW]), 16'h1111, "out6 payload");

    // R7: idle input with a clashing stale tag does not block
    clear_cells();
    cv[0] = 1'b0; cd[0] = 3; cx[0] = 16'hdead;
    cv[4] = 1'b1; cd[4] = 2; cx[4] = 16'h4444;
    apply_and_compare();
    check_val("R7", int'(ack[4]), 1, "ack4 beside idle input");
    check_val("R7", int'(ack[0]), 0, "ack0 idle");
    check_val("R7", int'(out_v[2]), 1, "out2 valid");
    check_val("R8", int'(out_x[3*DW +: DW]), 0, "idle out3 payload");

    // R3: all full permutations, count the ones delivered intact
    full_ok = 0;
    for (int idx = 0; idx < 40320; idx++) begin
      int rem;
      bit used[N];
      rem = idx;
      for (int i = 0; i < N; i++) used[i] = 1'b0;
      for (int p = 0; p < N; p++) begin
        int f, sel, c;
        f = 1;
        for (int q = 2; q <= N - 1 - p; q++) f *= q;
        sel = rem / f;
        rem = rem % f;
        c = 0;
        for (int v = 0; v < N; v++) begin
          if (!used[v]) begin
            if (c == sel) begin cd[p] = v; used[v] = 1'b1; end
            c++;
          end
        end
        cv[p] = 1'b1;
        cx[p] = (idx * 7 + p * 911) & 16'hffff;
      end
      apply_and_compare();
      if (ack == 8'hff) full_ok++;
    end
    check_val("R3", full_ok, 4096, "unblocked permutation count");

    // random partial loads with repeated tags
    for (int r = 0; r < 3000; r++) begin
      for (int i = 0; i < N; i++) begin
        cv[i] = ($urandom % 4) != 0;
        cd[i] = $urandom % N;
        cx[i] = $urandom % 65536;
      end
      apply_and_compare();
    end

    // R7: all inputs idle
    clear_cells();
    apply_and_compare();
    check_val("R7", int'(ack), 0, "no acks when idle");

    finish_run();
  end
endmodule